// File: doc/BRIEF.md
# Trace Timestamp Interval Generator

This block tells a trace source when to emit a timestamp packet. A 4-bit interval setting picks one of three behaviours. Zero means no timestamps. Fifteen means sync-only: timestamps appear only at sync points. Any value from one to fourteen runs a free down-counter whose period is a power of two in clock cycles.

Sync points come from a byte accumulator. The trace source strobes `byte_valid` together with the number of trace bytes it has just produced. When the running total reaches the programmed sync period, the block requests a sync packet. Software normally programs a period of 4096 bytes. Whenever timestamps are enabled, each sync request also raises a timestamp request. Packet encoding and the source of the timestamp value live outside this block.

Top module: `ts_interval_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ts_req` and `sync_req` are both low.
- R2: With `interval` = 0, `ts_req` stays low in every cycle, whatever the byte strobes do.
- R3: With `interval` = i held in 1..14, `ts_req` pulses once every 2^(i-1) cycles. With i = 1 it is high in every cycle.
- R4: When `interval` changes to i in 1..14, the counter restarts from 2^(i-1). The first `ts_req` comes exactly 2^(i-1)+1 clock edges after the new value is first sampled, counting that edge as the first.
- R5: With `interval` = 15, no counter-driven timestamps occur: `ts_req` is high only in cycles where `sync_req` is high.
- R6: Each strobe adds `byte_count` to a byte total. `sync_req` is high in the cycle after a strobe that makes the total reach or pass `sync_period`, and the total then restarts at zero, discarding any excess.
- R7: With `sync_period` = 0, `sync_req` never asserts and the byte total is held at zero.
- R8: For `interval` in 1..15, every `sync_req` cycle also has `ts_req` high, and a sync that coincides with a counter expiry gives a single request. With `interval` = 0, `sync_req` still pulses but `ts_req` does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | SEL_W (4) | Timestamp setting: 0 off, 1..14 periodic, 15 sync-only |
| sync_period | input | PER_W (13) | Bytes between sync requests; 0 disables sync |
| byte_valid | input | 1 | Strobe: trace bytes emitted this cycle |
| byte_count | input | BYTE_W (4) | Bytes emitted with the strobe |
| ts_req | output | 1 | Timestamp request, registered |
| sync_req | output | 1 | Sync request, registered |

## Verification
The assertions that look back through `$past` assume the inputs came from a real post-reset history, so the checker keeps its own count of cycles since reset and arms those checks only after enough cycles have passed. They also assume `byte_count` stays below 2^BYTE_W, so the byte total never wraps. The bench drives every input on the falling edge and changes `interval` only in a cycle with no strobe, which keeps the counter path and the sync path separate when each is measured. Sync periods stay well below the counter width, and every strobe is followed by an idle cycle so that each strobe's result can be read on its own.

// File: rtl/ts_interval_gen.sv
module ts_interval_gen #(
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 14,
  parameter int PER_W  = 13,
  parameter int BYTE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  interval,
  input  logic [PER_W-1:0]  sync_period,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_count,
  output logic              ts_req,
  output logic              sync_req
);
  localparam logic [SEL_W-1:0] SEL_OFF  = '0;
  localparam logic [SEL_W-1:0] SEL_SYNC = '1;
  localparam int               ACC_W    = PER_W + 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;

  wire              periodic  = (interval != SEL_OFF) && (interval != SEL_SYNC);
  wire              changed   = (interval != sel_q);
  wire [CNT_W-1:0]  reload    = CNT_W'(1) << (interval - SEL_W'(1));
  wire              cnt_fire  = periodic && !changed && (cnt_q == CNT_W'(1));
  wire [ACC_W-1:0]  acc_sum   = acc_q + ACC_W'(byte_count);
  wire              per_on    = (sync_period != '0);
  wire              sync_fire = byte_valid && per_on && (acc_sum >= ACC_W'(sync_period));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      ts_req   <= 1'b0;
      sync_req <= 1'b0;
    end else begin
      sel_q <= interval;

      if (!periodic)
        cnt_q <= '0;
      else if (changed || cnt_fire)
        cnt_q <= reload;
      else
        cnt_q <= cnt_q - CNT_W'(1);

      if (!per_on)
        acc_q <= '0;
      else if (byte_valid)
        acc_q <= sync_fire ? '0 : acc_sum;

      sync_req <= sync_fire;
      ts_req   <= cnt_fire || (sync_fire && (interval != SEL_OFF));
    end
  end
endmodule

// File: rtl/ts_interval_gen_chk.sv
module ts_interval_gen_chk #(
  parameter int SEL_W  = 4,
  parameter int PER_W  = 13,
  parameter int BYTE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  interval,
  input logic [PER_W-1:0]  sync_period,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_count,
  input logic              ts_req,
  input logic              sync_req
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (rst_n && age == 3'd0) |-> (!ts_req && !sync_req));

  // R2
  off_no_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(interval) == '0) |-> !ts_req);

  // R3
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $past(interval) == SEL_W'(1) && $past(interval, 2) == SEL_W'(1)
     && $past(interval, 3) == SEL_W'(1)) |-> ts_req);

  // R5
  sync_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(interval) == '1 && !sync_req) |-> !ts_req);

  // R6
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && sync_req) |-> $past(byte_valid));

  // R7
  no_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(sync_period) == '0) |-> !sync_req);

  // R8
  sync_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && sync_req && $past(interval) != '0) |-> ts_req);

  logic unused_in;
  assign unused_in = ^byte_count;
endmodule

bind ts_interval_gen ts_interval_gen_chk #(
  .SEL_W(SEL_W), .PER_W(PER_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .interval(interval), .sync_period(sync_period),
  .byte_valid(byte_valid), .byte_count(byte_count),
  .ts_req(ts_req), .sync_req(sync_req)
);

// File: tb/ts_interval_gen_test.sv
`timescale 1ns/1ps
module ts_interval_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  interval = 4'd0;
  logic [12:0] sync_period = 13'd0;
  logic        byte_valid = 1'b0;
  logic [3:0]  byte_count = 4'd0;
  logic        ts_req, sync_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ts_interval_gen uut (
    .clk(clk), .rst_n(rst_n), .interval(interval), .sync_period(sync_period),
    .byte_valid(byte_valid), .byte_count(byte_count),
    .ts_req(ts_req), .sync_req(sync_req)
  );

  localparam int NV = 8;
  localparam int VEC_IV [NV]  = '{1, 2, 3, 4, 6, 9, 11, 14};
  localparam int VEC_PER[NV]  = '{1, 2, 4, 8, 32, 256, 1024, 8192};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one strobe then an idle cycle; returns outputs seen after the strobe edge
  task automatic strobe(input int n, output bit s, output bit t);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_count = 4'(n);
    @(negedge clk);
    byte_valid = 1'b0;
    byte_count = 4'd0;
    s = sync_req;
    t = ts_req;
  endtask

  task automatic measure(input int iv, input int per);
    int first = 0;
    int gap   = 0;
    @(negedge clk);
    interval = 4'(iv);
    for (int n = 1; n <= 20000; n++) begin
      @(negedge clk);
      if (ts_req) begin first = n; break; end
    end
    // R4: first request after R+1 edges
    check(first == per + 1, "R4", first, per + 1);
    for (int n = 1; n <= 20000; n++) begin
      @(negedge clk);
      if (ts_req) begin gap = n; break; end
    end
    // R3: period 2^(i-1)
    check(gap == per, "R3", gap, per);
  endtask

  initial begin
    #(800_000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit s, t;
    int cnt;
    repeat (3) @(negedge clk);
    // R1
    check(!ts_req && !sync_req, "R1", {ts_req, sync_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ts_req && !sync_req, "R1", {ts_req, sync_req}, 0);

    for (int k = 0; k < NV; k++) measure(VEC_IV[k], VEC_PER[k]);

    // R4: mid-count change restarts from new reload
    measure(5, 16);
    measure(2, 2);

    // R2: off, no strobes
    @(negedge clk);
    interval = 4'd0;
    cnt = 0;
    repeat (60) begin @(negedge clk); if (ts_req) cnt++; end
    check(cnt == 0, "R2", cnt, 0);

    // R6 / R8: accumulation with interval 0 -> sync without ts
    sync_period = 13'd10;
    strobe(4, s, t); check(!s, "R6", s, 0);
    strobe(4, s, t); check(!s, "R6", s, 0);
    strobe(4, s, t); check(s, "R6", s, 1);
    check(!t, "R8", t, 0);
    strobe(7, s, t); check(!s, "R6", s, 0);
    strobe(2, s, t); check(!s, "R6", s, 0);
    strobe(1, s, t); check(s, "R6", s, 1);
    // excess discarded
    strobe(7, s, t); check(!s, "R6", s, 0);
    strobe(7, s, t); check(s, "R6", s, 1);
    strobe(7, s, t); check(!s, "R6", s, 0);
    strobe(2, s, t); check(!s && !t, "R2", {s, t}, 0);
    strobe(1, s, t); check(s, "R6", s, 1);

    // R5: sync-only
    @(negedge clk);
    interval = 4'd15;
    cnt = 0;
    repeat (100) begin @(negedge clk); if (ts_req) cnt++; end
    check(cnt == 0, "R5", cnt, 0);
    strobe(15, s, t);
    check(s && t, "R5", {s, t}, 3);

    // R8: periodic plus sync
    @(negedge clk);
    interval = 4'd9;
    repeat (5) @(negedge clk);
    strobe(12, s, t);
    check(s && t, "R8", {s, t}, 3);
    @(negedge clk);
    interval = 4'd1;
    repeat (3) @(negedge clk);
    strobe(10, s, t);
    check(s && t, "R8", {s, t}, 3);

    // R7: period 0 disables sync and clears total
    @(negedge clk);
    interval = 4'd15;
    strobe(5, s, t);
    sync_period = 13'd0;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin strobe(15, s, t); if (s || t) cnt++; end
    check(cnt == 0, "R7", cnt, 0);
    sync_period = 13'd10;
    strobe(9, s, t);
    check(!s, "R7", s, 0);
    strobe(1, s, t);
    check(s, "R7", s, 1);

    // R1: reset mid-run
    @(negedge clk);
    interval = 4'd1;
    rst_n = 1'b0;
    @(negedge clk);
    check(!ts_req && !sync_req, "R1", {ts_req, sync_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ts_req, "R1", ts_req, 0);

    done = 1'b1;
    finish_run();
  end
endmodule